// File: doc/BRIEF.md
# Converter Setup and Calibration Sequencer

This block is a one-shot bring-up engine for a multi-setup delta-sigma converter with a serial port. A single-cycle start pulse, together with a 4-bit depth value, launches a fixed series of serial transactions with the chip select held low:

- It reads the converter's 24-bit configuration register.
- It puts the requested depth into the depth field and leaves every other bit as it was read.
- It writes the register back.
- It sends the setup-write command and streams one 24-bit setup word per pair of setups.
- It issues a self-offset calibration on the first setup.
- It then watches the converter's data-out line. That line goes high while the calibration runs and falls when the calibration is finished.

The depth value is the number of setups to load minus one. Setups are stored two per 24-bit word, so the value must be odd. An even value is refused at once. A calibration that never signals completion is cut off by a cycle timeout.

The serial port runs in mode 0 and sends the most significant bit first. Each bit takes two system clocks: one with the serial clock low, then one with it high. The controller samples the data-in line on the clock edge that ends the high phase. The setup words come from a parameter table, and word 0 is sent first.

Top module: `setupCalSeq`

## Requirements
- R1: While reset is held and after it is released, stateOut is 0 (idle), csN is 1, and sclk, done and error are 0.
- R2: A start pulse whose depth has bit 0 equal to 0 moves stateOut to 8 (fail) on the next cycle. error goes high, and no serial activity takes place (csN stays 1).
- R3: With an odd depth, the first frame is 32 bits: command 0x0B followed by 24 bits read MSB-first from the data-in line. Each bit spends one clock with sclk low and one with sclk high, and mosi does not change while sclk is high.
- R4: The second frame is command 0x03 followed by the word that was read, with bits [DEPTH_LSB+3:DEPTH_LSB] (default bits 6..3) replaced by depth and every other bit unchanged.
- R5: The third frame is command 0x05 followed by depth/2+1 words of 24 bits, taken from the setup table in order from word 0. The default table holds 0x000000 and then 0x4C0105, with zeros after that.
- R6: The fourth frame is the single byte 0x81, which starts the self-offset calibration.
- R7: In the calibration wait (stateOut 6), csN stays 0 and sclk stays 0. A high-to-low transition of miso moves stateOut to 7 (done) on the next cycle.
- R8: If no falling edge of miso arrives within CAL_TIMEOUT wait cycles, stateOut becomes 8 (fail). A fall seen in the last allowed cycle still ends in done.
- R9: State codes are 0 idle, 1 config read, 2 config write, 3 setup command, 4 setup data, 5 calibration command, 6 calibration wait, 7 done, 8 fail. A transfer of L bits keeps its state for 2L+2 cycles, and that count applies to each setup word in turn.
- R10: done and error hold until the next start. A start seen while a sequence is running has no effect, and done and error are never high together.
- R11: csN is 0 from the first cycle after an accepted start until done or fail is reached. sclk is never high while csN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| depth | input | 4 | Number of setups minus one, captured at start |
| miso | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| done | output | 1 | Sequence completed |
| error | output | 1 | Depth refused or calibration timed out |
| stateOut | output | 4 | Current sequencer state code |

## Verification
The bench computes, from R9, the exact number of cycles each state lasts: 66 for each configuration frame, 18 for each command byte, and 50 for each setup word. The calibration wait lasts the smaller of the emulated converter's latency and CAL_TIMEOUT. The bench then compares stateOut, done, error and csN against that timeline at every falling clock edge. The emulated converter changes miso only after an sclk fall and captures mosi after an sclk rise, so each read bit is settled a full high phase before the design samples it. The frame contents (R3 to R6) are checked once a run ends, and the refusal in R2 is expected exactly one cycle after the start pulse.

// File: rtl/setupCalPkg.sv
package setupCalPkg;
  localparam int DEPTH_W   = 4;
  localparam int MAX_WORDS = 1 << (DEPTH_W - 1);
  localparam int WORD_W    = 24;
  localparam int CMD_W     = 8;
  localparam int FRAME_W   = CMD_W + WORD_W;
  localparam int LEN_W     = $clog2(FRAME_W + 1);

  localparam logic [CMD_W-1:0] OP_CFG_RD  = 8'h0B;
  localparam logic [CMD_W-1:0] OP_CFG_WR  = 8'h03;
  localparam logic [CMD_W-1:0] OP_SET_WR  = 8'h05;
  localparam logic [CMD_W-1:0] OP_CAL_OFS = 8'h81;

  typedef enum logic [3:0] {
    S_IDLE       = 4'd0,
    S_CFG_READ   = 4'd1,
    S_CFG_WRITE  = 4'd2,
    S_SETUP_CMD  = 4'd3,
    S_SETUP_DATA = 4'd4,
    S_CAL_CMD    = 4'd5,
    S_CAL_WAIT   = 4'd6,
    S_DONE       = 4'd7,
    S_FAIL       = 4'd8
  } seqState_t;

  // strobes from control to the serial datapath
  typedef struct packed {
    logic               load;
    logic [LEN_W-1:0]   len;
    logic [FRAME_W-1:0] data;  // left aligned, MSB leaves first
  } xferCmd_t;
endpackage

// File: rtl/setupCalShift.sv
module setupCalShift
  import setupCalPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  xferCmd_t          cmd,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              xferDone,
  output logic [WORD_W-1:0] rxWord
);
  logic [FRAME_W-1:0] shReg;
  logic [LEN_W-1:0]   bitsLeft;
  logic               active;
  logic               phaseHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      bitsLeft  <= '0;
      active    <= 1'b0;
      phaseHigh <= 1'b0;
      xferDone  <= 1'b0;
      rxWord    <= '0;
    end else begin
      xferDone <= 1'b0;
      if (cmd.load) begin
        shReg     <= cmd.data;
        bitsLeft  <= cmd.len;
        active    <= 1'b1;
        phaseHigh <= 1'b0;
      end else if (active) begin
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else begin
          phaseHigh <= 1'b0;
          shReg     <= {shReg[FRAME_W-2:0], 1'b0};
          rxWord    <= {rxWord[WORD_W-2:0], miso};
          bitsLeft  <= bitsLeft - LEN_W'(1);
          if (bitsLeft == LEN_W'(1)) begin
            active   <= 1'b0;
            xferDone <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk = active & phaseHigh;
  assign mosi = active & shReg[FRAME_W-1];
endmodule

// File: rtl/setupCalCtrl.sv
module setupCalCtrl
  import setupCalPkg::*;
#(
  parameter int DEPTH_LSB   = 3,
  parameter int CAL_TIMEOUT = 4096,
  parameter logic [MAX_WORDS*WORD_W-1:0] SETUP_WORDS = '0
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               miso,
  input  logic               xferDone,
  input  logic [WORD_W-1:0]  rxWord,
  output xferCmd_t           cmd,
  output logic               csN,
  output logic [3:0]         stateOut,
  output logic               done,
  output logic               error
);
  localparam int WAIT_W = $clog2(CAL_TIMEOUT) + 1;
  localparam int IDX_W  = DEPTH_W - 1;

  seqState_t          state;
  logic               issued;
  logic [DEPTH_W-1:0] depthQ;
  logic [IDX_W-1:0]   wordIdx;
  logic [WORD_W-1:0]  cfgQ;
  logic [WORD_W-1:0]  cfgMod;
  logic [WAIT_W-1:0]  waitCnt;
  logic               misoQ;
  logic               restState;
  logic               lastWord;
  logic               misoFell;

  assign restState = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);
  assign lastWord  = (wordIdx == depthQ[DEPTH_W-1:1]);
  assign misoFell  = misoQ & ~miso;

  always_comb begin
    cfgMod = cfgQ;
    cfgMod[DEPTH_LSB +: DEPTH_W] = depthQ;
  end

  always_comb begin
    cmd = '0;
    if (!issued) begin
      unique case (state)
        S_CFG_READ:   begin cmd.load = 1'b1; cmd.len = LEN_W'(FRAME_W); cmd.data = {OP_CFG_RD, {WORD_W{1'b0}}}; end
        S_CFG_WRITE:  begin cmd.load = 1'b1; cmd.len = LEN_W'(FRAME_W); cmd.data = {OP_CFG_WR, cfgMod}; end
        S_SETUP_CMD:  begin cmd.load = 1'b1; cmd.len = LEN_W'(CMD_W);   cmd.data = {OP_SET_WR, {WORD_W{1'b0}}}; end
        S_SETUP_DATA: begin cmd.load = 1'b1; cmd.len = LEN_W'(WORD_W);
                            cmd.data = {SETUP_WORDS[wordIdx*WORD_W +: WORD_W], {CMD_W{1'b0}}}; end
        S_CAL_CMD:    begin cmd.load = 1'b1; cmd.len = LEN_W'(CMD_W);   cmd.data = {OP_CAL_OFS, {WORD_W{1'b0}}}; end
        default:      cmd = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      issued  <= 1'b0;
      depthQ  <= '0;
      wordIdx <= '0;
      cfgQ    <= '0;
      waitCnt <= '0;
      misoQ   <= 1'b0;
    end else begin
      misoQ <= miso;
      if (cmd.load) issued <= 1'b1;
      if (restState) begin
        if (start) begin
          depthQ <= depth;
          issued <= 1'b0;
          state  <= depth[0] ? S_CFG_READ : S_FAIL;
        end
      end else if (state == S_CAL_WAIT) begin
        if (misoFell) begin
          state <= S_DONE;
        end else if (waitCnt == WAIT_W'(CAL_TIMEOUT - 1)) begin
          state <= S_FAIL;
        end else begin
          waitCnt <= waitCnt + WAIT_W'(1);
        end
      end else if (xferDone) begin
        issued <= 1'b0;
        unique case (state)
          S_CFG_READ:  begin cfgQ <= rxWord; state <= S_CFG_WRITE; end
          S_CFG_WRITE: state <= S_SETUP_CMD;
          S_SETUP_CMD: begin wordIdx <= '0; state <= S_SETUP_DATA; end
          S_SETUP_DATA: begin
            if (lastWord) state <= S_CAL_CMD;
            else wordIdx <= wordIdx + IDX_W'(1);
          end
          S_CAL_CMD:   begin waitCnt <= '0; state <= S_CAL_WAIT; end
          default:     state <= S_FAIL;
        endcase
      end
    end
  end

  assign csN      = restState;
  assign stateOut = state;
  assign done     = (state == S_DONE);
  assign error    = (state == S_FAIL);
endmodule

// File: rtl/setupCalSeq.sv
module setupCalSeq
  import setupCalPkg::*;
#(
  parameter int DEPTH_LSB   = 3,
  parameter int CAL_TIMEOUT = 4096,
  parameter logic [MAX_WORDS*WORD_W-1:0] SETUP_WORDS =
    {{(MAX_WORDS-2){24'h000000}}, 24'h4C0105, 24'h000000}
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] depth,
  input  logic       miso,
  output logic       csN,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic       error,
  output logic [3:0] stateOut
);
  xferCmd_t          xferCmd;
  logic              xferDone;
  logic [WORD_W-1:0] rxWord;

  setupCalCtrl #(
    .DEPTH_LSB(DEPTH_LSB), .CAL_TIMEOUT(CAL_TIMEOUT), .SETUP_WORDS(SETUP_WORDS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .depth(depth), .miso(miso),
    .xferDone(xferDone), .rxWord(rxWord), .cmd(xferCmd), .csN(csN),
    .stateOut(stateOut), .done(done), .error(error)
  );

  setupCalShift shift_i (
    .clk(clk), .rstN(rstN), .cmd(xferCmd), .miso(miso),
    .sclk(sclk), .mosi(mosi), .xferDone(xferDone), .rxWord(rxWord)
  );
endmodule

// File: rtl/setupCalSeqChk.sv
module setupCalSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       depthOdd,
  input logic       csN,
  input logic       sclk,
  input logic       mosi,
  input logic       done,
  input logic       error,
  input logic [3:0] stateOut
);
  logic atRest;
  assign atRest = (stateOut == 4'd0) || (stateOut == 4'd7) || (stateOut == 4'd8);

  a_r2_even_depth_refused: assert property (@(posedge clk) disable iff (!rstN)
    (start && !depthOdd && atRest) |=> (stateOut == 4'd8 && csN && error));

  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));

  a_r7_wait_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 4'd6) |-> (!csN && !sclk));

  a_r8_wait_exits: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 4'd6) |=> (stateOut == 4'd6 || stateOut == 4'd7 || stateOut == 4'd8));

  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 4'd1 && start) |=> (stateOut == 4'd1 || stateOut == 4'd2));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  a_r11_sclk_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);
endmodule

bind setupCalSeq setupCalSeqChk chk_i (
  .clk(clk), .rstN(rstN), .start(start), .depthOdd(depth[0]), .csN(csN),
  .sclk(sclk), .mosi(mosi), .done(done), .error(error), .stateOut(stateOut)
);

// File: tb/setupCalSeq_tb.sv
module setupCalSeq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] depth = 4'd0;
  logic miso = 1'b0;
  logic csN, sclk, mosi, done, error;
  logic [3:0] stateOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  setupCalSeq #(.CAL_TIMEOUT(TO)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .depth(depth), .miso(miso),
    .csN(csN), .sclk(sclk), .mosi(mosi), .done(done), .error(error),
    .stateOut(stateOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // converter model
  logic [23:0] cfgReg = 24'h0;
  int calLat = 0;
  int calCnt = 0;
  int slaveWords = 0;
  int bitIdx = 0;
  int dataBits = 0;
  logic [7:0] cmdSh = 8'h0;
  logic [7:0] curCmd = 8'h0;
  logic [23:0] dataSh = 24'h0;
  logic prevSclk = 1'b0;
  logic [7:0] cmdLog[$];
  logic [23:0] wordLog[$];

  always @(negedge clk) begin
    if (calCnt > 0) begin
      calCnt = calCnt - 1;
      if (calCnt == 0) miso = 1'b0;
    end
    if (csN) begin
      bitIdx = 0;
    end else if (sclk && !prevSclk) begin
      if (bitIdx < 8) cmdSh = {cmdSh[6:0], mosi};
      else dataSh = {dataSh[22:0], mosi};
      bitIdx = bitIdx + 1;
    end else if (!sclk && prevSclk) begin
      if (bitIdx == 8) begin
        curCmd = cmdSh;
        cmdLog.push_back(cmdSh);
        case (cmdSh)
          8'h0B, 8'h03: dataBits = 24;
          8'h05: dataBits = 24 * slaveWords;
          default: dataBits = 0;
        endcase
        if (cmdSh == 8'h81) begin
          miso = 1'b1;
          calCnt = calLat;
        end
      end
      if (curCmd == 8'h0B && bitIdx >= 8 && bitIdx < 32) miso = cfgReg[23 - (bitIdx - 8)];
      if ((curCmd == 8'h03 || curCmd == 8'h05) && bitIdx > 8 && ((bitIdx - 8) % 24) == 0)
        wordLog.push_back(dataSh);
      if (bitIdx == 8 + dataBits) begin
        bitIdx = 0;
        if (curCmd == 8'h0B) miso = 1'b0;
      end
    end
    prevSclk = sclk;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the expected state (R9, R10, R11)
  task automatic cmpState(input int e);
    bit rest;
    rest = (e == 0 || e == 7 || e == 8);
    check(stateOut == 4'(e), "R9", "stateOut", 32'(stateOut), 32'(e));
    check(done == (e == 7), "R10", "done", 32'(done), 32'(e == 7));
    check(error == (e == 8), "R10", "error", 32'(error), 32'(e == 8));
    check(csN == rest, "R11", "csN", 32'(csN), 32'(rest));
    if (rest) check(sclk == 1'b0, "R11", "sclk idle", 32'(sclk), 32'h0);
  endtask

  task automatic runSeq(input logic [3:0] d, input logic [23:0] cfg, input int lat,
                        input bit pokeBusy);
    int q[$];
    int n;
    int idx;
    int last;
    logic [23:0] expCfg;
    n = int'(d >> 1) + 1;
    cmdLog.delete();
    wordLog.delete();
    cfgReg = cfg;
    calLat = lat;
    calCnt = 0;
    slaveWords = n;
    if (!d[0]) begin
      q.push_back(8);
    end else begin
      repeat (66) q.push_back(1);
      repeat (66) q.push_back(2);
      repeat (18) q.push_back(3);
      repeat (50 * n) q.push_back(4);
      repeat (18) q.push_back(5);
      repeat ((lat <= TO) ? lat : TO) q.push_back(6);
      q.push_back((lat <= TO) ? 7 : 8);
    end
    @(negedge clk);
    start = 1'b1;
    depth = d;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    last = 0;
    while (q.size() > 0) begin
      last = q.pop_front();
      cmpState(last);
      if (pokeBusy && idx == 30) begin
        start = 1'b1;   // R10: ignored while busy
        depth = 4'd0;
      end else begin
        start = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    repeat (5) begin
      cmpState(last);  // R10: result held
      @(negedge clk);
    end
    if (!d[0]) begin
      check(cmdLog.size() == 0, "R2", "frames sent", 32'(cmdLog.size()), 32'h0);
    end else begin
      expCfg = cfg;
      expCfg[3 +: 4] = d;
      check(cmdLog.size() == 4, "R3", "frame count", 32'(cmdLog.size()), 32'd4);
      if (cmdLog.size() == 4) begin
        check(cmdLog[0] == 8'h0B, "R3", "read command", 32'(cmdLog[0]), 32'h0B);
        check(cmdLog[1] == 8'h03, "R4", "write command", 32'(cmdLog[1]), 32'h03);
        check(cmdLog[2] == 8'h05, "R5", "setup command", 32'(cmdLog[2]), 32'h05);
        check(cmdLog[3] == 8'h81, "R6", "calibration command", 32'(cmdLog[3]), 32'h81);
      end
      check(wordLog.size() == n + 1, "R5", "word count", 32'(wordLog.size()), 32'(n + 1));
      if (wordLog.size() == n + 1) begin
        check(wordLog[0] == expCfg, "R4", "config write-back", 32'(wordLog[0]), 32'(expCfg));
        for (int w = 0; w < n; w++) begin
          logic [23:0] ew;
          ew = (w == 1) ? 24'h4C0105 : 24'h000000;
          check(wordLog[w + 1] == ew, "R5", "setup word", 32'(wordLog[w + 1]), 32'(ew));
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmpState(0);  // R1 under reset
    rstN = 1'b1;
    @(negedge clk);
    cmpState(0);  // R1 after release
    check(mosi == 1'b0, "R1", "mosi", 32'(mosi), 32'h0);

    runSeq(4'b0010, 24'h123456, 10, 1'b0);   // R2 even depth refused
    runSeq(4'b0011, 24'hA5A5A5, 40, 1'b1);   // R3..R7, R10 busy start ignored
    runSeq(4'b1111, 24'h000000, TO, 1'b0);   // R8 fall in last allowed cycle, 8 words
    runSeq(4'b0001, 24'hFFFFFF, TO + 1, 1'b0); // R8 timeout
    runSeq(4'b0011, 24'h5A5A5A, 1, 1'b0);    // R7 shortest wait, restart from fail

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule